// File: doc/BRIEF.md
# Switchable 12/6-Clock Machine-Cycle Generator

This block derives the core timing of a small 8-bit controller from the crystal clock. In standard speed the crystal is first halved, so a machine cycle of six core clocks lasts twelve crystal periods. In double speed the halving stage is bypassed, and a machine cycle lasts six crystal periods. All outputs are enables and strobes that are synchronous to the crystal clock. No clock is muxed, so the whole core and its peripherals stay on a single clock tree.

Software selects the speed through bit 0 of a clock-control register. The written value is held as a request. It becomes the active mode only on the crystal edge at which the halved clock rises, so the core tick never shows a short gap. A phase state machine walks through six states, named PH_S1 to PH_S6, one state per core tick. It emits one strobe per phase and a machine-cycle tick at the end of PH_S6. Peripherals use that tick as their time base, so they run twice as fast in double speed. An address-latch pulse is produced twice per machine cycle. The first of the two pulses is dropped while the current cycle is an external data access. The pulse can also be silenced during internal fetches by bit 0 of an auxiliary register.

The divider state machine has two states. DIV_LO moves to DIV_HI on every crystal edge, and this transition is the rising edge of the halved clock. DIV_HI moves back to DIV_LO. The phase state machine moves PH_S1 → PH_S2 → PH_S3 → PH_S4 → PH_S5 → PH_S6 → PH_S1, one step on each crystal edge where `core_en` is high, and holds its state otherwise.

Top module: `mcycle_clkgen`

## Requirements
- R1: While `rst_n` is low, `speed_x2` is 0 (standard speed), the phase state is PH_S1, `core_en`, `phase_stb` and `mc_tick` are 0, and both control bits are cleared.
- R2: In standard speed, `core_en` is high on every second crystal cycle, and `mc_tick` repeats every 12 crystal cycles.
- R3: In double speed, `core_en` is high on every crystal cycle, and `mc_tick` repeats every 6 crystal cycles.
- R4: A write with `ckc_we` high loads `wdata[0]` as the requested mode (1 = double speed). `speed_x2` takes the request only on an edge at which the divider leaves DIV_LO, so the change shows within one or two crystal cycles after the write edge.
- R5: No mode change ever produces two `core_en` pulses in consecutive crystal cycles while standard speed is active on both of those cycles.
- R6: `phase_stb[k]` pulses for exactly one crystal cycle when `core_en` is high in phase k (bit 0 = PH_S1 through bit 5 = PH_S6). The phase advances only on such cycles.
- R7: `mc_tick` equals `phase_stb[5]`, so there is one tick per machine cycle, at the end of PH_S6.
- R8: `ale` is high throughout PH_S1 and PH_S4 and low in all other phases. This gives two pulses per machine cycle: one pulse per six crystal periods in standard speed, and one per three in double speed.
- R9: While `xdata_cyc` is high, the PH_S1 pulse of `ale` is suppressed and the PH_S4 pulse remains.
- R10: A write with `aux_we` high loads `wdata[0]` as the latch-suppress bit. While that bit is 1 and `int_fetch` is high, `ale` stays low. When `int_fetch` is low, the bit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal | input | 1 | Crystal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ckc_we | input | 1 | Write strobe for the clock-control register |
| aux_we | input | 1 | Write strobe for the auxiliary register |
| wdata | input | 8 | Write data; bit 0 is the control bit of either register |
| xdata_cyc | input | 1 | Current machine cycle is an external data access |
| int_fetch | input | 1 | Current fetch is from internal program memory |
| core_en | output | 1 | Core clock enable, one crystal cycle wide |
| phase_stb | output | 6 | One-hot phase strobes, bit k marks the end of phase k+1 |
| mc_tick | output | 1 | Machine-cycle tick for peripherals |
| ale | output | 1 | Address-latch pulse |
| speed_x2 | output | 1 | Active speed mode, 1 = double speed |

## Verification
The bench writes the mode bit at both alignments of the halved clock, and switches in both directions. A design that applied the bit at once would switch the mode on the wrong edge. It would then emit back-to-back core enables in standard speed, or shift the phase sequence by one cycle. The bench measures the machine-cycle period in each speed. A divider that was not bypassed, or a wrap at the wrong phase, would show up as a period of 24 or 12 cycles where 12 or 6 is expected. The bench counts latch pulses over one machine cycle with the external-access and suppress inputs in every combination. A skip placed on the wrong pulse, or a suppress that also acted outside internal fetches, would change those counts.

// File: rtl/mcg_pkg.sv
package mcg_pkg;
    localparam int N_PH = 6;
    localparam int PH_W = $clog2(N_PH);

    typedef enum logic [PH_W-1:0] {
        PH_S1 = 3'd0,
        PH_S2 = 3'd1,
        PH_S3 = 3'd2,
        PH_S4 = 3'd3,
        PH_S5 = 3'd4,
        PH_S6 = 3'd5
    } phase_e;

    typedef enum logic {
        DIV_LO = 1'b0,
        DIV_HI = 1'b1
    } div_e;
endpackage

// File: rtl/mcg_divsel.sv
module mcg_divsel (
    input  logic clk,
    input  logic rst_n,
    input  logic req_we,
    input  logic req_bit,
    output logic core_en,
    output logic x2_act
);
    import mcg_pkg::*;

    div_e div_q, div_d;
    logic req_q;
    logic x2_q;

    // divider state machine
    always_comb begin
        unique case (div_q)
            DIV_LO:  div_d = DIV_HI;
            DIV_HI:  div_d = DIV_LO;
            default: div_d = DIV_LO;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= DIV_LO;
            req_q <= 1'b0;
            x2_q  <= 1'b0;
        end else begin
            div_q <= div_d;
            if (req_we) req_q <= req_bit;
            // mode taken only as the halved clock rises
            if (div_q == DIV_LO) x2_q <= req_q;
        end
    end

    // output process
    always_comb begin
        x2_act  = x2_q;
        core_en = x2_q || (div_q == DIV_HI);
    end

    p_sync_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (x2_q != $past(x2_q)) |-> (div_q == DIV_HI));

    p_no_runt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!x2_q && !$past(x2_q) && core_en) |-> !$past(core_en));
endmodule

// File: rtl/mcg_phase_fsm.sv
module mcg_phase_fsm (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 core_en,
    output mcg_pkg::phase_e      phase,
    output logic [mcg_pkg::N_PH-1:0] phase_stb
);
    import mcg_pkg::*;

    phase_e ph_q, ph_d;

    always_comb begin
        ph_d = ph_q;
        if (core_en) begin
            unique case (ph_q)
                PH_S1:   ph_d = PH_S2;
                PH_S2:   ph_d = PH_S3;
                PH_S3:   ph_d = PH_S4;
                PH_S4:   ph_d = PH_S5;
                PH_S5:   ph_d = PH_S6;
                PH_S6:   ph_d = PH_S1;
                default: ph_d = PH_S1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH_S1;
        else        ph_q <= ph_d;
    end

    // output process
    always_comb begin
        phase = ph_q;
        for (int k = 0; k < N_PH; k++) begin
            phase_stb[k] = core_en && (int'(ph_q) == k);
        end
    end

    p_stb_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phase_stb));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !core_en |=> $stable(ph_q));
endmodule

// File: rtl/mcg_ale_gen.sv
module mcg_ale_gen (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sup_we,
    input  logic            sup_bit,
    input  mcg_pkg::phase_e phase,
    input  logic            xdata_cyc,
    input  logic            int_fetch,
    output logic            ale
);
    import mcg_pkg::*;

    logic sup_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sup_q <= 1'b0;
        else if (sup_we) sup_q <= sup_bit;
    end

    // output process
    always_comb begin
        ale = 1'b0;
        unique case (phase)
            PH_S1:   ale = !xdata_cyc;
            PH_S4:   ale = 1'b1;
            default: ale = 1'b0;
        endcase
        if (sup_q && int_fetch) ale = 1'b0;
    end

    p_ale_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (phase == PH_S1 || phase == PH_S4));

    p_skip_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xdata_cyc && phase == PH_S1) |-> !ale);
endmodule

// File: rtl/mcycle_clkgen.sv
module mcycle_clkgen #(
    parameter int DW       = 8,
    parameter int MODE_BIT = 0,
    parameter int SUP_BIT  = 0
) (
    input  logic                     clk_xtal,
    input  logic                     rst_n,
    input  logic                     ckc_we,
    input  logic                     aux_we,
    input  logic [DW-1:0]            wdata,
    input  logic                     xdata_cyc,
    input  logic                     int_fetch,
    output logic                     core_en,
    output logic [mcg_pkg::N_PH-1:0] phase_stb,
    output logic                     mc_tick,
    output logic                     ale,
    output logic                     speed_x2
);
    import mcg_pkg::*;

    phase_e phase;
    logic   unused_wbits;

    assign unused_wbits = ^wdata;

    mcg_divsel u_div (
        .clk     (clk_xtal),
        .rst_n   (rst_n),
        .req_we  (ckc_we),
        .req_bit (wdata[MODE_BIT]),
        .core_en (core_en),
        .x2_act  (speed_x2)
    );

    mcg_phase_fsm u_ph (
        .clk       (clk_xtal),
        .rst_n     (rst_n),
        .core_en   (core_en),
        .phase     (phase),
        .phase_stb (phase_stb)
    );

    mcg_ale_gen u_ale (
        .clk       (clk_xtal),
        .rst_n     (rst_n),
        .sup_we    (aux_we),
        .sup_bit   (wdata[SUP_BIT]),
        .phase     (phase),
        .xdata_cyc (xdata_cyc),
        .int_fetch (int_fetch),
        .ale       (ale)
    );

    assign mc_tick = phase_stb[N_PH-1];

    p_tick_end_r7: assert property (@(posedge clk_xtal) disable iff (!rst_n)
        mc_tick |-> (phase == PH_S6 && core_en));

    p_fast_r3: assert property (@(posedge clk_xtal) disable iff (!rst_n)
        (speed_x2 && $past(speed_x2)) |-> core_en);
endmodule

// File: tb/tb_mcycle_clkgen.sv
module tb_mcycle_clkgen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ckc_we = 1'b0, aux_we = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       xdata_cyc = 1'b0, int_fetch = 1'b0;
    logic       core_en, mc_tick, ale, speed_x2;
    logic [5:0] phase_stb;

    int checks = 0, failures = 0, cyc = 0;
    bit run_chk = 1'b0, done = 1'b0;

    // reference model state
    int m_half = 0, m_x2 = 0, m_req = 0, m_aux = 0, m_ph = 0;

    always #5 clk = ~clk;

    mcycle_clkgen dut (
        .clk_xtal(clk), .rst_n(rst_n), .ckc_we(ckc_we), .aux_we(aux_we),
        .wdata(wdata), .xdata_cyc(xdata_cyc), .int_fetch(int_fetch),
        .core_en(core_en), .phase_stb(phase_stb), .mc_tick(mc_tick),
        .ale(ale), .speed_x2(speed_x2)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s cyc=%0d act=%0d exp=%0d", req, cyc, act, exp);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_half = 0; m_x2 = 0; m_req = 0; m_aux = 0; m_ph = 0;
        end else begin
            int en, nx2;
            en  = (m_x2 != 0 || m_half != 0) ? 1 : 0;
            nx2 = (m_half == 0) ? m_req : m_x2;
            if (en != 0) m_ph = (m_ph + 1) % 6;
            m_x2   = nx2;
            m_half = 1 - m_half;
            if (ckc_we) m_req = int'(wdata[0]);
            if (aux_we) m_aux = int'(wdata[0]);
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (run_chk && !done) begin
            int en, ea;
            en = (m_x2 != 0 || m_half != 0) ? 1 : 0;
            ea = ((m_ph == 0 && !xdata_cyc) || m_ph == 3) ? 1 : 0;
            if (m_aux != 0 && int_fetch) ea = 0;
            chk("R2/R3 core_en", int'(core_en), en);
            chk("R6 phase_stb", int'(phase_stb), en != 0 ? (1 << m_ph) : 0);
            chk("R7 mc_tick", int'(mc_tick), (en != 0 && m_ph == 5) ? 1 : 0);
            chk("R8/R9/R10 ale", int'(ale), ea);
            chk("R4 speed_x2", int'(speed_x2), m_x2);
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(bit ckc, logic [7:0] v);
        @(posedge clk); #1;
        ckc_we = ckc; aux_we = !ckc; wdata = v;
        @(posedge clk); #1;
        ckc_we = 1'b0; aux_we = 1'b0;
    endtask

    task automatic period(int exp, string tag);
        int n = 0;
        do @(negedge clk); while (!mc_tick);
        do begin @(negedge clk); n++; end while (!mc_tick);
        chk(tag, n, exp);
    endtask

    task automatic ale_count(int exp, string tag);
        int n = 0;
        do @(negedge clk); while (!mc_tick);
        repeat (speed_x2 ? 6 : 12) begin
            @(negedge clk);
            if (ale) n++;
        end
        chk(tag, n, exp);
    endtask

    initial begin
        run_chk = 1'b1;
        step(3);
        // R1: reset state
        @(negedge clk);
        chk("R1 speed_x2 in reset", int'(speed_x2), 0);
        chk("R1 core_en in reset", int'(core_en), 0);
        chk("R1 phase_stb in reset", int'(phase_stb), 0);
        chk("R1 mc_tick in reset", int'(mc_tick), 0);
        @(posedge clk); #1 rst_n = 1'b1;

        // R2: standard speed
        period(12, "R2 std period");
        period(12, "R2 std period again");
        ale_count(4, "R8 std two pulses of 2 cycles");

        // R3/R4: switch to double speed, bits 7:1 set too
        wr(1'b1, 8'hFF);
        step(2);
        chk("R4 mode active", int'(speed_x2), 1);
        period(6, "R3 x2 period");
        ale_count(2, "R8 x2 two pulses");

        // R9: skip first pulse on external data cycle
        xdata_cyc = 1'b1;
        ale_count(1, "R9 x2 skip");
        // R10: suppress during internal fetch
        wr(1'b0, 8'h01);
        int_fetch = 1'b1;
        ale_count(0, "R10 suppressed");
        int_fetch = 1'b0;
        ale_count(1, "R10 no effect without fetch");
        xdata_cyc = 1'b0;
        wr(1'b0, 8'h00);
        int_fetch = 1'b1;
        ale_count(2, "R10 bit cleared");
        int_fetch = 1'b0;

        // R4/R5: switch back at both divider alignments
        wr(1'b1, 8'hFE);
        step(3);
        chk("R4 back to std", int'(speed_x2), 0);
        period(12, "R2 std after switch");
        for (int off = 0; off < 4; off++) begin
            step(off + 1);
            wr(1'b1, 8'h01);
            step(5 + off);
            wr(1'b1, 8'h00);
            step(7);
        end
        period(12, "R5 std after toggles");
        xdata_cyc = 1'b1;
        ale_count(2, "R9 std skip");
        xdata_cyc = 1'b0;

        // R1: reset mid-run in double speed
        wr(1'b1, 8'h01);
        step(9);
        #2 rst_n = 1'b0;
        @(negedge clk);
        chk("R1 async reset mode", int'(speed_x2), 0);
        chk("R1 async reset stb", int'(phase_stb), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        period(12, "R1 std after reset");
        step(20);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule